// File: doc/BRIEF.md
# Short-Circuit Diagnostic Sequencer

This block sits beside each output channel of a power amplifier. It decides what happens after that channel's short-circuit protection trips. In restart mode the channel is muted and is re-examined on every millisecond tick until the overload has gone. In diagnostic mode a trip first gets a one-tick glitch check. If the overload survives that check, a timed acquisition window runs, and the window records which comparator faults stayed present for its whole length.

At the end of the window the surviving fault with the highest priority is latched, together with the kind of diagnostic that ran, and a done flag is raised. The channel then falls back to restart mode. It stays in restart mode until a register read sends a re-arm pulse, so each read returns the outcome of the cycle before it.

The comparators and the test-current pulse are outside this block. One status byte per channel is assembled here for the register file to read.

Top module: `scdiag_seq`

## Requirements
- R1: When diagnostics are disabled or the channel is not armed, a trip seen while the channel runs raises mute on the next clock. Mute then stays high until a clock with the millisecond tick high and the trip low, after which it drops on the next clock.
- R2: When diagnostics are enabled and the channel is armed, a trip mutes the channel and waits for the next tick. If the trip is low at that tick, the channel unmutes. No acquisition runs, and the done flag and the status byte are unchanged.
- R3: If the trip is still high at that tick, an acquisition window of WIN_MS further ticks runs, and mute stays high throughout.
- R4: At the final tick of the window the results are latched and done goes to 1. The channel is then in restart mode (see R1), and mute stays high until a tick with the trip low.
- R5: A fault is reported only if its comparator flag was high on every clock from the window's first clock through its final tick.
- R6: After a window completes, the channel is disarmed. Further trips are handled as in R1 until a re-arm pulse arrives. The re-arm clears done, and the latched fault bits stay as they were until the next window completes.
- R7: Status byte per channel, bits: 7 = 0, 6 = done, 5 = 0, 4 = kind (0 turn-on, 1 permanent), 3 = shorted load, 2 = open load, 1 = short to supply, 0 = short to ground. Channel c occupies stat_o[8c+7:8c].
- R8: At most one fault bit is latched. The priority is short to supply, then short to ground, then shorted load, then open load.
- R9: The kind of a window is sampled from turnon_i when the window starts (1 means turn-on, recorded as kind 0). Open load can be latched only in a turn-on window and is never reported after a permanent one.
- R10: After reset, every mute and done output is 0, every status byte is 0, and every channel is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_ms_i | input | 1 | One-clock pulse every millisecond |
| diag_en_i | input | 1 | Diagnostic mode enable |
| turnon_i | input | 1 | Window started now is a turn-on diagnostic |
| rearm_i | input | 1 | One-clock pulse from a status read |
| trip_i | input | NCH | Protection trip, one per channel |
| flt_gnd_i | input | NCH | Short-to-ground comparator |
| flt_sup_i | input | NCH | Short-to-supply comparator |
| flt_sld_i | input | NCH | Shorted-load comparator |
| flt_open_i | input | NCH | Open-load comparator |
| mute_o | output | NCH | Channel mute/shutdown request |
| done_o | output | NCH | Acquisition completed since last re-arm |
| stat_o | output | 8*NCH | Status bytes |

## Verification
The hardest state to reach is a window whose faults overlap and only some of them persist. Two channels are tripped together, with several comparators high. One comparator is dropped for a single clock in the middle of the window, so persistence (R5) and priority (R8) are both visible in the latched bytes. The disarmed path is reached by tripping a channel again after a completed window and before any re-arm, and then checking that the byte is unchanged. A behavioural model in the bench follows every clock, including the tick phase at which each trip lands.

// File: rtl/scdiag_pkg.sv
package scdiag_pkg;
    // Channel sequencer states
    typedef enum logic [1:0] {CH_RUN, CH_SHUT, CH_GLITCH, CH_ACQ} ch_state_e;
    // Comparator fault set, MSB is the highest priority
    typedef struct packed {
        logic sup;
        logic gnd;
        logic sld;
        logic opn;
    } flt_t;
    localparam int STAT_W = 8;
endpackage

// File: rtl/scdiag_win_timer.sv
// Window timer: counts millisecond ticks inside an acquisition window.
// Assumes clr and adv are never high together; last_o marks tick WIN_MS-1.
module scdiag_win_timer #(
    parameter int WIN_MS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic last_o
);
    localparam int CW = $clog2(WIN_MS + 1);
    logic [CW-1:0] cnt_q;

    // Tick counter, restarted at each window entry
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (adv) cnt_q <= cnt_q + 1'b1;
    end

    assign last_o = (cnt_q == CW'(WIN_MS - 1));

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(WIN_MS - 1));
endmodule

// File: rtl/scdiag_persist.sv
// Persistence accumulator: a fault bit survives only while its flag stays high.
// Assumes load marks the first clock of a window and upd every later one.
module scdiag_persist (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       upd,
    input  logic [3:0] flags,
    output logic [3:0] nx_o
);
    logic [3:0] pers_q;

    // Value including this clock's flags
    assign nx_o = pers_q & flags;

    // Load at window entry, then AND on every clock
    always_ff @(posedge clk) begin
        if (!rst_n)    pers_q <= '0;
        else if (load) pers_q <= flags;
        else if (upd)  pers_q <= nx_o;
    end

    assert_persist_monotone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !load) |=> ((pers_q & ~$past(pers_q)) == 4'b0000));
endmodule

// File: rtl/scdiag_chan.sv
// One channel: restart/glitch/acquisition sequencing, result latch, status byte.
// Assumes tick_i is a one-clock pulse and rearm_i a one-clock pulse.
module scdiag_chan
    import scdiag_pkg::*;
#(
    parameter int WIN_MS = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              diag_en_i,
    input  logic              turnon_i,
    input  logic              rearm_i,
    input  logic              trip_i,
    input  flt_t              flt_i,
    output logic              mute_o,
    output logic              done_o,
    output logic [STAT_W-1:0] stat_o
);
    ch_state_e st_q, st_d;
    logic      armed_q, done_q, perm_q, res_perm_q;
    logic      start_acq, finish, tmr_last;
    flt_t      flt_m, pers_nx, res_q, res_d;

    assign start_acq = (st_q == CH_GLITCH) && tick_i && trip_i;
    assign finish    = (st_q == CH_ACQ) && tick_i && tmr_last;

    // Open load counts only in a turn-on window
    always_comb begin
        flt_m = flt_i;
        if (start_acq) flt_m.opn = flt_i.opn & turnon_i;
        else           flt_m.opn = flt_i.opn & ~perm_q;
    end

    scdiag_persist u_pers (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start_acq),
        .upd   (st_q == CH_ACQ),
        .flags (flt_m),
        .nx_o  (pers_nx)
    );

    scdiag_win_timer #(.WIN_MS(WIN_MS)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start_acq),
        .adv    ((st_q == CH_ACQ) && tick_i && !tmr_last),
        .last_o (tmr_last)
    );

    // Next-state selection
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_RUN:    if (trip_i) st_d = (diag_en_i && armed_q) ? CH_GLITCH : CH_SHUT;
            CH_SHUT:   if (tick_i && !trip_i) st_d = CH_RUN;
            CH_GLITCH: if (tick_i) st_d = trip_i ? CH_ACQ : CH_RUN;
            CH_ACQ:    if (finish) st_d = CH_SHUT;
            default:   st_d = CH_RUN;
        endcase
    end

    // Fixed-priority pick of the surviving fault
    always_comb begin
        res_d = '0;
        if (pers_nx.sup)      res_d.sup = 1'b1;
        else if (pers_nx.gnd) res_d.gnd = 1'b1;
        else if (pers_nx.sld) res_d.sld = 1'b1;
        else if (pers_nx.opn) res_d.opn = 1'b1;
    end

    // State, arming, done flag and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= CH_RUN;
            armed_q    <= 1'b1;
            done_q     <= 1'b0;
            perm_q     <= 1'b0;
            res_perm_q <= 1'b0;
            res_q      <= '0;
        end else begin
            st_q <= st_d;
            if (start_acq) perm_q <= ~turnon_i;
            if (finish) begin
                res_q      <= res_d;
                res_perm_q <= perm_q;
                done_q     <= 1'b1;
                armed_q    <= 1'b0;
            end else if (rearm_i) begin
                done_q  <= 1'b0;
                armed_q <= 1'b1;
            end
        end
    end

    assign mute_o = (st_q != CH_RUN);
    assign done_o = done_q;
    assign stat_o = {1'b0, done_q, 1'b0, res_perm_q, res_q.sld, res_q.opn, res_q.sup, res_q.gnd};

    assert_trip_mutes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_RUN && trip_i) |=> mute_o);
    assert_shut_waits_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_SHUT && !tick_i) |=> (st_q == CH_SHUT));
    assert_unarmed_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_RUN && trip_i && !armed_q) |=> (st_q == CH_SHUT));
    assert_done_from_acq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> ($past(st_q) == CH_ACQ));
    assert_single_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(res_q));
    assert_open_turnon_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_q.opn |-> !res_perm_q);
endmodule

// File: rtl/scdiag_seq.sv
// Top: one diagnostic sequencer per output channel with shared tick and re-arm.
// Assumes all inputs are synchronous to clk.
module scdiag_seq
    import scdiag_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int WIN_MS = 100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_ms_i,
    input  logic                  diag_en_i,
    input  logic                  turnon_i,
    input  logic                  rearm_i,
    input  logic [NCH-1:0]        trip_i,
    input  logic [NCH-1:0]        flt_gnd_i,
    input  logic [NCH-1:0]        flt_sup_i,
    input  logic [NCH-1:0]        flt_sld_i,
    input  logic [NCH-1:0]        flt_open_i,
    output logic [NCH-1:0]        mute_o,
    output logic [NCH-1:0]        done_o,
    output logic [NCH*STAT_W-1:0] stat_o
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        flt_t fv;
        assign fv.sup = flt_sup_i[g];
        assign fv.gnd = flt_gnd_i[g];
        assign fv.sld = flt_sld_i[g];
        assign fv.opn = flt_open_i[g];

        scdiag_chan #(.WIN_MS(WIN_MS)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_i    (tick_ms_i),
            .diag_en_i (diag_en_i),
            .turnon_i  (turnon_i),
            .rearm_i   (rearm_i),
            .trip_i    (trip_i[g]),
            .flt_i     (fv),
            .mute_o    (mute_o[g]),
            .done_o    (done_o[g]),
            .stat_o    (stat_o[g*STAT_W +: STAT_W])
        );
    end
endmodule

// File: tb/tb_scdiag_seq.sv
module tb_scdiag_seq;
    localparam int NCH = 2, WIN = 10, TPER = 4;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, den = 1'b0, ton = 1'b0, rearm = 1'b0;
    logic [NCH-1:0] trip = '0, fg = '0, fs = '0, fl = '0, fo = '0;
    logic [NCH-1:0] mute, done;
    logic [NCH*8-1:0] stat;
    int ncmp = 0, nbad = 0, tphase = 0;

    // Behavioural model state; fault order {sup,gnd,sld,open}
    int       m_ph[NCH];   // 0 run, 1 shut, 2 glitch, 3 window
    int       m_cnt[NCH];
    bit       m_arm[NCH], m_done[NCH], m_kind[NCH], m_rperm[NCH];
    bit [3:0] m_pers[NCH], m_res[NCH];

    always #4 clk = ~clk;

    scdiag_seq #(.NCH(NCH), .WIN_MS(WIN)) dut (
        .clk(clk), .rst_n(rst_n), .tick_ms_i(tick), .diag_en_i(den), .turnon_i(ton),
        .rearm_i(rearm), .trip_i(trip), .flt_gnd_i(fg), .flt_sup_i(fs), .flt_sld_i(fl),
        .flt_open_i(fo), .mute_o(mute), .done_o(done), .stat_o(stat)
    );

    function automatic bit [3:0] pick(bit [3:0] p);
        if (p[3]) return 4'b1000;
        if (p[2]) return 4'b0100;
        if (p[1]) return 4'b0010;
        if (p[0]) return 4'b0001;
        return 4'b0000;
    endfunction

    function automatic bit [7:0] exp_stat(int c);
        return {1'b0, m_done[c], 1'b0, m_rperm[c], m_res[c][1], m_res[c][0], m_res[c][3], m_res[c][2]};
    endfunction

    task automatic model_edge();
        for (int c = 0; c < NCH; c++) begin
            if (!rst_n) begin
                m_ph[c] = 0; m_cnt[c] = 0; m_arm[c] = 1; m_done[c] = 0;
                m_kind[c] = 0; m_rperm[c] = 0; m_pers[c] = 0; m_res[c] = 0;
            end else begin
                bit fin = 0;
                case (m_ph[c])
                    0: if (trip[c]) m_ph[c] = (den && m_arm[c]) ? 2 : 1;
                    1: if (tick && !trip[c]) m_ph[c] = 0;
                    2: if (tick) begin
                        if (!trip[c]) m_ph[c] = 0;
                        else begin
                            m_ph[c] = 3; m_cnt[c] = 0; m_kind[c] = !ton;
                            m_pers[c] = {fs[c], fg[c], fl[c], fo[c] & ton};
                        end
                    end
                    default: begin
                        m_pers[c] = m_pers[c] & {fs[c], fg[c], fl[c], fo[c] & !m_kind[c]};
                        if (tick) begin
                            if (m_cnt[c] == WIN - 1) begin
                                fin = 1; m_res[c] = pick(m_pers[c]); m_rperm[c] = m_kind[c];
                                m_done[c] = 1; m_arm[c] = 0; m_ph[c] = 1;
                            end else m_cnt[c]++;
                        end
                    end
                endcase
                if (rearm && !fin) begin m_arm[c] = 1; m_done[c] = 0; end
            end
        end
    endtask

    task automatic chk(string tag, int act, int exp);
        ncmp++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: model follows the edge, outputs compared 2 ns later
    task automatic step();
        @(posedge clk);
        model_edge();
        #2;
        for (int c = 0; c < NCH; c++) begin
            chk($sformatf("R1/R2/R3 mute ch%0d", c), mute[c], m_ph[c] != 0);
            chk($sformatf("R4/R6 done ch%0d", c), done[c], m_done[c]);
            chk($sformatf("R7 status ch%0d", c), stat[c*8 +: 8], exp_stat(c));
        end
        tphase++;
        tick = (tphase % TPER == TPER - 1);
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic after_tick();
        for (int i = 0; i < 2 * TPER && !tick; i++) step();
        step();
    endtask

    task automatic wait_done(int c);
        for (int i = 0; i < (WIN + 3) * TPER * 2 && !done[c]; i++) step();
    endtask

    task automatic pulse_rearm();
        rearm = 1'b1; step(); rearm = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        nbad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
    end

    initial begin
        steps(3);
        rst_n = 1'b1;
        chk("R10 reset status", stat, 0);
        chk("R10 reset mute", mute, 0);
        chk("R10 reset done", done, 0);
        steps(2);

        // R1: restart mode with diagnostics off
        trip[0] = 1; step();
        chk("R1 mute on trip", mute[0], 1);
        steps(10);
        chk("R1 mute held", mute[0], 1);
        trip[0] = 0; steps(TPER + 1);
        chk("R1 released", mute[0], 0);

        // R2: glitch cleared before the check tick
        den = 1; after_tick();
        trip[0] = 1; step(); trip[0] = 0;
        steps(TPER + 1);
        chk("R2 resumed", mute[0], 0);
        chk("R2 no cycle", stat[7:0], 0);

        // R3/R4: permanent window with persistent short to ground
        fg[0] = 1; trip[0] = 1;
        steps(3 * TPER);
        chk("R3 muted in window", mute[0], 1);
        wait_done(0);
        chk("R4 latched gnd", stat[7:0], 8'h51);
        chk("R4 still muted", mute[0], 1);
        chk("R4 other channel", stat[15:8], 0);

        // R6: disarmed, new trips only restart
        fg[0] = 0; steps(3 * TPER);
        trip[0] = 0; steps(TPER + 1);
        chk("R4 restart release", mute[0], 0);
        trip[0] = 1; steps(3 * TPER); trip[0] = 0; steps(TPER + 1);
        chk("R6 no new window", stat[7:0], 8'h51);
        pulse_rearm();
        chk("R6 rearm clears done only", stat[7:0], 8'h11);

        // R5/R8: overlapping faults, one dropped for a clock
        fs[0] = 1; fg[0] = 1; fl[0] = 1;
        fg[1] = 1; fl[1] = 1;
        trip = 2'b11;
        steps(3 * TPER);
        fg = 2'b00; step(); fg = 2'b11;
        wait_done(0); wait_done(1);
        chk("R8 supply outranks", stat[7:0], 8'h52);
        chk("R5 dropped gnd not kept", stat[15:8], 8'h58);
        trip = 0; fs = 0; fg = 0; fl = 0;
        steps(TPER + 1);
        pulse_rearm();

        // R9: open load in a turn-on window, ignored in a permanent one
        ton = 1; fo[0] = 1; trip[0] = 1;
        wait_done(0);
        chk("R9 turn-on open", stat[7:0], 8'h44);
        trip[0] = 0; steps(TPER + 1);
        pulse_rearm();
        ton = 0; trip[0] = 1;
        wait_done(0);
        chk("R9 permanent hides open", stat[7:0], 8'h50);
        trip[0] = 0; fo[0] = 0; steps(TPER + 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
    end
endmodule